// File: doc/BRIEF.md
# Debug Single-Step Trace Sequencer

This block is the control engine inside an on-chip debug unit that carries out a single-step request from the host while the processor sits halted in debug mode. On an accepted step command it takes the saved return address off the stack and restores the interrupt enable if it was on when debug mode began. It then hands the processor exactly the one instruction at that address and freezes the core once it completes. Further fetches are held off while the sequencer puts the next-instruction address back on the stack, forces the instruction pointer to the fixed debug entry vector, turns interrupts off again and re-halts the core.

The host sees a two-bit status: not in debug, debug-idle or debug-busy. The stack, the processor core, program memory and the host link sit outside the block and are reached through simple request/acknowledge handshakes and one-cycle strobes.

Top module: `trace_step_seq`

## Requirements
- R1: Status encoding is 2'b00 outside debug mode, 2'b01 for debug-idle and 2'b10 for debug-busy. After reset it reads 2'b00. One cycle after a `dbgEnter` pulse from 2'b00 it reads 2'b01. One cycle after a `dbgExit` pulse from debug-idle it reads 2'b00.
- R2: A `traceCmd` pulse accepted in debug-idle makes status 2'b10 in the next cycle, and `popReq` rises in that same cycle.
- R3: `popReq` stays high until the cycle in which `popAck` is high. `popData` is taken in that cycle. `cpuRun` stays low while `popReq` is high.
- R4: `igeIn` is latched on `dbgEnter`. If the latched value is 1, a single-cycle write with `igeWe`=1 and `igeVal`=1 follows the pop. If it is 0, no enabling write occurs.
- R5: `cpuRun` is high with `instrAddr` equal to the popped address until `instrDone`, and the stepped instruction is supplied only once.
- R6: From the cycle after `instrDone` until the halt step, `cpuStall` and `fetchBlock` are both high and `cpuRun` is low.
- R7: `pushData` equals the `cpuNextIp` value present in the first cycle of the stall. `pushReq` stays high until `pushAck`.
- R8: After the push completes, `ipLoad` pulses for one cycle with `ipLoadVal` = 16'h8010.
- R9: In the cycle after the `ipLoad` pulse, `igeWe`=1 with `igeVal`=0, whatever value was latched at entry.
- R10: After the clear, `cpuHalt` is high for a cycle with status still 2'b10. Status then returns to 2'b01 with `cpuHalt` still high.
- R11: `traceCmd` is ignored when status is 2'b00 or 2'b10. No pop occurs and the status is unchanged.
- R12: Step events occur in this order: pop, enable restore (when latched), instruction supply, stall with fetch block, push, revector, enable clear, halt, idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbgEnter | input | 1 | Pulse: core has entered debug mode |
| dbgExit | input | 1 | Pulse: leave debug mode (honoured only when idle) |
| igeIn | input | 1 | Interrupt global enable value at debug entry |
| traceCmd | input | 1 | Host single-step command strobe |
| status | output | 2 | Host status: 00 off, 01 idle, 10 busy |
| popReq | output | 1 | Stack pop request |
| popAck | input | 1 | Stack pop acknowledge, `popData` valid |
| popData | input | ADDR_W | Return address from the stack |
| pushReq | output | 1 | Stack push request |
| pushAck | input | 1 | Stack push acknowledge |
| pushData | output | ADDR_W | Address pushed to the stack |
| igeWe | output | 1 | Write strobe for the interrupt enable bit |
| igeVal | output | 1 | Value written with `igeWe` |
| cpuRun | output | 1 | Release core to execute the supplied instruction |
| instrAddr | output | ADDR_W | Address of the supplied instruction |
| instrDone | input | 1 | Core finished the supplied instruction |
| cpuNextIp | input | ADDR_W | Core's next-instruction pointer |
| cpuStall | output | 1 | Hold the core after the stepped instruction |
| fetchBlock | output | 1 | Suppress program-memory fetch |
| cpuHalt | output | 1 | Core halted in debug mode |
| ipLoad | output | 1 | Force the instruction pointer |
| ipLoadVal | output | ADDR_W | Value forced into the instruction pointer |

## Verification
The bench varies pop, execution and push latencies. A design that samples the return address before the acknowledge, or lets the core run during the pop, delivers the wrong `instrAddr` or gets the order wrong. `cpuNextIp` is valid only in the first stall cycle, so capturing it one cycle early or late pushes a junk address. Entry with the interrupt enable both on and off shows whether the restore is conditional and the final clear unconditional. Step commands sent outside debug mode and in the middle of a step must leave status and stack untouched, and must not start a second step afterwards.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_POP,
    ST_IGE_ON,
    ST_EXEC,
    ST_STALL,
    ST_PUSH,
    ST_VECT,
    ST_IGE_OFF,
    ST_HALT
  } seqState_t;

  typedef struct packed {
    logic enterDbg;
    logic exitDbg;
    logic acceptCmd;
    logic latchRet;
    logic captureNext;
    logic finish;
  } seqStrobe_t;

  localparam logic [1:0] STAT_OFF  = 2'b00;
  localparam logic [1:0] STAT_IDLE = 2'b01;
  localparam logic [1:0] STAT_BUSY = 2'b10;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import dbg_trace_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       traceCmd,
  input  logic       dbgEnter,
  input  logic       dbgExit,
  input  logic       popAck,
  input  logic       pushAck,
  input  logic       instrDone,
  input  logic       inDebug,
  input  logic       savedIge,
  output seqStrobe_t strobe,
  output logic       popReq,
  output logic       pushReq,
  output logic       cpuRun,
  output logic       cpuStall,
  output logic       fetchBlock,
  output logic       cpuHalt,
  output logic       ipLoad,
  output logic       igeWe,
  output logic       igeVal
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_WAIT;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_WAIT:    if (inDebug && traceCmd) stateD = ST_POP;
      ST_POP:     if (popAck) stateD = ST_IGE_ON;
      ST_IGE_ON:  stateD = ST_EXEC;
      ST_EXEC:    if (instrDone) stateD = ST_STALL;
      ST_STALL:   stateD = ST_PUSH;
      ST_PUSH:    if (pushAck) stateD = ST_VECT;
      ST_VECT:    stateD = ST_IGE_OFF;
      ST_IGE_OFF: stateD = ST_HALT;
      ST_HALT:    stateD = ST_WAIT;
      default:    stateD = ST_WAIT;
    endcase
  end

  logic inWait, postExec;
  assign inWait   = (stateQ == ST_WAIT);
  assign postExec = (stateQ == ST_STALL) || (stateQ == ST_PUSH) ||
                    (stateQ == ST_VECT)  || (stateQ == ST_IGE_OFF);

  always_comb begin
    strobe             = '0;
    strobe.enterDbg    = inWait && !inDebug && dbgEnter;
    strobe.exitDbg     = inWait && inDebug && dbgExit && !traceCmd;
    strobe.acceptCmd   = inWait && inDebug && traceCmd;
    strobe.latchRet    = (stateQ == ST_POP) && popAck;
    strobe.captureNext = (stateQ == ST_STALL);
    strobe.finish      = (stateQ == ST_HALT);
  end

  assign popReq     = (stateQ == ST_POP);
  assign pushReq    = (stateQ == ST_PUSH);
  assign cpuRun     = (stateQ == ST_EXEC);
  assign cpuStall   = postExec;
  assign fetchBlock = postExec;
  assign cpuHalt    = inDebug && !cpuRun && !postExec;
  assign ipLoad     = (stateQ == ST_VECT);
  assign igeWe      = ((stateQ == ST_IGE_ON) && savedIge) || (stateQ == ST_IGE_OFF);
  assign igeVal     = (stateQ == ST_IGE_ON);

  // R3: the pop request is held until the stack acknowledges
  a_r3_pop_held : assert property (@(posedge clk) disable iff (!rstN)
    popReq && !popAck |=> popReq);

  // R5: the instruction is released only after the pop and restore steps
  a_r5_run_after_restore : assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRun) |-> $past(stateQ) == ST_IGE_ON);

  // R6: completion of the stepped instruction freezes the core next cycle
  a_r6_stall_after_done : assert property (@(posedge clk) disable iff (!rstN)
    cpuRun && instrDone |=> cpuStall && fetchBlock && !cpuRun);

  // R7: the push request is held until acknowledged
  a_r7_push_held : assert property (@(posedge clk) disable iff (!rstN)
    pushReq && !pushAck |=> pushReq);

  // R8: a completed push is followed by the revector
  a_r8_vect_after_push : assert property (@(posedge clk) disable iff (!rstN)
    pushReq && pushAck |=> ipLoad);

  // R9: the revector is followed by the interrupt enable clear
  a_r9_clear_after_vect : assert property (@(posedge clk) disable iff (!rstN)
    ipLoad |=> igeWe && !igeVal);

  // R12: at most one step action is active in any cycle
  a_r12_single_action : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({popReq, pushReq, cpuRun, ipLoad, igeWe}));

endmodule

// File: rtl/trace_dpath.sv
module trace_dpath
  import dbg_trace_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              igeIn,
  input  logic [ADDR_W-1:0] popData,
  input  logic [ADDR_W-1:0] cpuNextIp,
  input  logic              pushReq,
  input  logic              pushAck,
  output logic              inDebug,
  output logic              savedIge,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] instrAddr,
  output logic [ADDR_W-1:0] pushData
);

  logic              inDebugQ, busyQ, savedIgeQ;
  logic [ADDR_W-1:0] retAddrQ, nextIpQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inDebugQ  <= 1'b0;
      busyQ     <= 1'b0;
      savedIgeQ <= 1'b0;
    end else begin
      if (strobe.enterDbg) begin
        inDebugQ  <= 1'b1;
        savedIgeQ <= igeIn;
      end
      if (strobe.exitDbg)   inDebugQ <= 1'b0;
      if (strobe.acceptCmd) busyQ    <= 1'b1;
      if (strobe.finish)    busyQ    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retAddrQ <= '0;
      nextIpQ  <= '0;
    end else begin
      if (strobe.latchRet)    retAddrQ <= popData;
      if (strobe.captureNext) nextIpQ  <= cpuNextIp;
    end
  end

  assign inDebug   = inDebugQ;
  assign savedIge  = savedIgeQ;
  assign instrAddr = retAddrQ;
  assign pushData  = nextIpQ;
  assign status    = busyQ ? STAT_BUSY : (inDebugQ ? STAT_IDLE : STAT_OFF);

  // R2: an accepted command reports busy on the following cycle
  a_r2_busy_after_accept : assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptCmd |=> status == STAT_BUSY);

  // R7: pushed address does not move while the push waits
  a_r7_push_stable : assert property (@(posedge clk) disable iff (!rstN)
    pushReq && !pushAck |=> $stable(pushData));

  // R10: the final step returns the status to debug-idle
  a_r10_idle_after_finish : assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> status == STAT_IDLE);

  // R1: leaving debug mode reports not-in-debug
  a_r1_exit_off : assert property (@(posedge clk) disable iff (!rstN)
    strobe.exitDbg |=> status == STAT_OFF);

endmodule

// File: rtl/trace_step_seq.sv
module trace_step_seq
  import dbg_trace_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] DBG_VECTOR = 16'h8010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgEnter,
  input  logic              dbgExit,
  input  logic              igeIn,
  input  logic              traceCmd,
  output logic [1:0]        status,
  output logic              popReq,
  input  logic              popAck,
  input  logic [ADDR_W-1:0] popData,
  output logic              pushReq,
  input  logic              pushAck,
  output logic [ADDR_W-1:0] pushData,
  output logic              igeWe,
  output logic              igeVal,
  output logic              cpuRun,
  output logic [ADDR_W-1:0] instrAddr,
  input  logic              instrDone,
  input  logic [ADDR_W-1:0] cpuNextIp,
  output logic              cpuStall,
  output logic              fetchBlock,
  output logic              cpuHalt,
  output logic              ipLoad,
  output logic [ADDR_W-1:0] ipLoadVal
);

  seqStrobe_t strobe;
  logic       inDebug, savedIge;

  trace_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .traceCmd(traceCmd), .dbgEnter(dbgEnter),
    .dbgExit(dbgExit), .popAck(popAck), .pushAck(pushAck),
    .instrDone(instrDone), .inDebug(inDebug), .savedIge(savedIge),
    .strobe(strobe), .popReq(popReq), .pushReq(pushReq), .cpuRun(cpuRun),
    .cpuStall(cpuStall), .fetchBlock(fetchBlock), .cpuHalt(cpuHalt),
    .ipLoad(ipLoad), .igeWe(igeWe), .igeVal(igeVal)
  );

  trace_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .igeIn(igeIn),
    .popData(popData), .cpuNextIp(cpuNextIp), .pushReq(pushReq),
    .pushAck(pushAck), .inDebug(inDebug), .savedIge(savedIge),
    .status(status), .instrAddr(instrAddr), .pushData(pushData)
  );

  assign ipLoadVal = DBG_VECTOR;

  // R4: enabling interrupts happens only inside a step
  a_r4_enable_only_busy : assert property (@(posedge clk) disable iff (!rstN)
    igeWe && igeVal |-> status == STAT_BUSY);

  // R11: no stack traffic outside a step
  a_r11_no_pop_when_idle : assert property (@(posedge clk) disable iff (!rstN)
    status != STAT_BUSY |-> !popReq && !pushReq);

endmodule

// File: tb/tb_trace_step_seq.sv
module tb_trace_step_seq;

  logic        clk = 1'b0;
  logic        rstN, dbgEnter, dbgExit, igeIn, traceCmd;
  logic [1:0]  status;
  logic        popReq, popAck, pushReq, pushAck;
  logic [15:0] popData, pushData, instrAddr, cpuNextIp, ipLoadVal;
  logic        igeWe, igeVal, cpuRun, instrDone, cpuStall, fetchBlock;
  logic        cpuHalt, ipLoad;

  always #10 clk = ~clk;

  trace_step_seq dut (
    .clk(clk), .rstN(rstN), .dbgEnter(dbgEnter), .dbgExit(dbgExit),
    .igeIn(igeIn), .traceCmd(traceCmd), .status(status), .popReq(popReq),
    .popAck(popAck), .popData(popData), .pushReq(pushReq), .pushAck(pushAck),
    .pushData(pushData), .igeWe(igeWe), .igeVal(igeVal), .cpuRun(cpuRun),
    .instrAddr(instrAddr), .instrDone(instrDone), .cpuNextIp(cpuNextIp),
    .cpuStall(cpuStall), .fetchBlock(fetchBlock), .cpuHalt(cpuHalt),
    .ipLoad(ipLoad), .ipLoadVal(ipLoadVal)
  );

  int total = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector: ige, poke, exec[3:0], popLat[3:0], pushLat[3:0], ret[15:0], nxt[15:0]
  localparam int NV = 4;
  localparam logic [45:0] VECS [NV] = '{
    {1'b1, 1'b0, 4'd1, 4'd1, 4'd1, 16'h0120, 16'h0121},
    {1'b0, 1'b1, 4'd3, 4'd3, 4'd2, 16'h7FFE, 16'h0040},
    {1'b1, 1'b1, 4'd2, 4'd2, 4'd4, 16'hFFFF, 16'h0000},
    {1'b0, 1'b0, 4'd1, 4'd1, 4'd1, 16'h8010, 16'h8011}
  };

  logic [9:0] seen;
  int         logArr [16];
  int         logN;

  task automatic mark(input int code);
    if (!seen[code]) begin
      seen[code] = 1'b1;
      logArr[logN] = code;
      logN++;
    end
  endtask

  task automatic enterDebug(input logic ige);
    dbgEnter = 1'b1; igeIn = ige;
    @(negedge clk);
    dbgEnter = 1'b0; igeIn = 1'b0;
    check(status == 2'b01, "R1 enter", status, 2'b01);
  endtask

  task automatic exitDebug();
    dbgExit = 1'b1;
    @(negedge clk);
    dbgExit = 1'b0;
    check(status == 2'b00, "R1 exit", status, 2'b00);
  endtask

  task automatic doTrace(input logic [45:0] v);
    logic        ige, poke;
    int          execN, popLat, pushLat, popCnt, runCnt, pushCnt, n;
    logic [15:0] ret, nxt;
    bit          done;
    int          expSeq [10];
    ige = v[45]; poke = v[44];
    execN = int'(v[43:40]); popLat = int'(v[39:36]); pushLat = int'(v[35:32]);
    ret = v[31:16]; nxt = v[15:0];
    popCnt = 0; runCnt = 0; pushCnt = 0; done = 0;
    seen = '0; logN = 0;
    traceCmd = 1'b1;
    @(negedge clk);
    traceCmd = 1'b0;
    check(status == 2'b10, "R2 busy", status, 2'b10);
    check(popReq == 1'b1, "R2 pop rise", popReq, 1);
    for (int cyc = 0; cyc < 100 && !done; cyc++) begin
      popAck = 0; pushAck = 0; instrDone = 0; cpuNextIp = 16'hDEAD;
      popData = 16'h5A5A; traceCmd = 0;
      if (poke && cyc == 0) traceCmd = 1'b1;  // R11 command while busy
      if (popReq) begin
        mark(1); popCnt++;
        check(!cpuRun, "R3 no run during pop", cpuRun, 0);
        if (popCnt >= popLat) begin popAck = 1'b1; popData = ret; end
      end
      if (igeWe) mark(igeVal ? 2 : 7);
      if (cpuRun) begin
        mark(3); runCnt++;
        check(instrAddr == ret, "R5 instrAddr", instrAddr, ret);
        if (runCnt >= execN) instrDone = 1'b1;
      end
      if (cpuStall) begin
        if (!seen[4]) begin mark(4); cpuNextIp = nxt; end
        check(fetchBlock && !cpuRun, "R6 block", {fetchBlock, cpuRun}, 2'b10);
      end
      if (pushReq) begin
        mark(5); pushCnt++;
        check(pushData == nxt, "R7 pushData", pushData, nxt);
        if (pushCnt >= pushLat) pushAck = 1'b1;
      end
      if (ipLoad) begin
        mark(6);
        check(ipLoadVal == 16'h8010, "R8 vector", ipLoadVal, 16'h8010);
      end
      if (cpuHalt && status == 2'b10 && seen[7]) mark(8);
      if (status == 2'b01) begin
        mark(9);
        check(cpuHalt, "R10 halted at idle", cpuHalt, 1);
        done = 1;
      end
      if (!done) @(negedge clk);
    end
    popAck = 0; pushAck = 0; instrDone = 0; traceCmd = 0;
    check(done, "R10 returned to idle", done, 1);
    check(runCnt == execN, "R5 single supply", runCnt, execN);
    check(seen[2] == ige, "R4 conditional restore", seen[2], ige);
    check(seen[7], "R9 enable cleared", seen[7], 1);
    n = 0;
    expSeq[n++] = 1;
    if (ige) expSeq[n++] = 2;
    expSeq[n++] = 3; expSeq[n++] = 4; expSeq[n++] = 5; expSeq[n++] = 6;
    expSeq[n++] = 7; expSeq[n++] = 8; expSeq[n++] = 9;
    begin
      bit ok;
      ok = (logN == n);
      for (int k = 0; k < n && ok; k++) if (logArr[k] != expSeq[k]) ok = 0;
      check(ok, "R12 step order", logN, n);
    end
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(!popReq && status == 2'b01, "R11 busy command ignored",
              {popReq, status}, 3'b001);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rstN = 0; dbgEnter = 0; dbgExit = 0; igeIn = 0; traceCmd = 0;
    popAck = 0; popData = 0; pushAck = 0; instrDone = 0; cpuNextIp = 0;
    repeat (3) @(negedge clk);
    check(status == 2'b00, "R1 reset status", status, 0);
    check(!popReq && !pushReq && !cpuRun && !ipLoad && !igeWe,
          "R1 reset outputs idle", {popReq, pushReq, cpuRun, ipLoad, igeWe}, 0);
    rstN = 1;
    @(negedge clk);

    // R11: command outside debug mode
    traceCmd = 1'b1;
    @(negedge clk);
    traceCmd = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(status == 2'b00 && !popReq, "R11 off command ignored",
            {popReq, status}, 0);
      @(negedge clk);
    end

    for (int i = 0; i < NV; i++) begin
      enterDebug(VECS[i][45]);
      doTrace(VECS[i]);
      exitDebug();
    end

    // back-to-back steps in one debug session, enable latched on
    enterDebug(1'b1);
    doTrace(VECS[0]);
    doTrace(VECS[3] | 46'h2000000000 << 8);
    exitDebug();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule